// File: doc/BRIEF.md
# Reset State Manager

This block sequences the reset outputs of a chip from a single core-supply reset input. The input goes low on power-on, on brownout and on loss of voltage regulation. It runs on a slow clock. While the core-supply reset is low, all four active-low reset outputs are held low, and they drop at once, without waiting for a clock edge. These outputs serve the backup domain, the peripherals, the processor and the external reset pin.

When the core-supply reset is released, the block first passes it through a two-flop synchronizer. It then releases the outputs in a fixed order:

- the backup reset first;
- then the external pin, after a programmable stretch;
- then the peripheral and processor resets together, after a fixed startup interval.

A mode register holds the 4-bit stretch-length field, which gives a pin low time of 2^(len+1) cycles. A general reset returns this field to its reset value. A read-only status register holds a reset-type code, and that code is written only when the processor reset is released.

The sequencer is a four-state machine:

- **HOLD**: all outputs are asserted.
- **STRETCH**: the backup reset is released and the pin length is counted.
- **STARTUP**: the pin is released and the processor startup interval is counted.
- **RUN**: all outputs are released.

The transitions are:

- **HOLD→STRETCH** when the synchronized release is seen. The length field is captured at this point.
- **STRETCH→STARTUP** when the stretch count reaches its limit.
- **STARTUP→RUN** after the startup interval.
- **any→HOLD**, asynchronously, when the core-supply reset is asserted.

Top module: `rst_state_mgr`

## Requirements
- R1: While core_rst_n is low, bkup_rst_n, periph_rst_n, proc_rst_n and ext_rst_n are all low. They go low immediately on assertion, without a clock edge.
- R2: After core_rst_n rises, bkup_rst_n rises on the third rising slow_clk edge. Two of these edges are taken by the synchronizer.
- R3: ext_rst_n rises 2^(len+1) cycles after bkup_rst_n, where len is the value of the mode field at the edge that released bkup_rst_n. At len = 0 this is 2 cycles.
- R4: periph_rst_n and proc_rst_n rise together, STARTUP_CYC (2) cycles after ext_rst_n. Neither rises before ext_rst_n or bkup_rst_n.
- R5: rst_type reads 3'd7 (not yet recorded) from any core reset until the edge that releases proc_rst_n. From that edge on, it reads 3'd0 (general reset).
- R6: A mode_we pulse writes mode_wdata into the length field, and mode_rdata returns it. Asserting core_rst_n returns the field to the parameter LEN_RST.
- R7: A mode write made while a sequence is in progress leaves that sequence's pin length unchanged.
- R8: Asserting core_rst_n in the middle of a sequence returns all outputs low. The next release runs the full sequence with the timing of R2 to R4.
- R9: Once released, all four outputs stay high until core_rst_n is next asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| slow_clk | input | 1 | Slow sequencing clock |
| core_rst_n | input | 1 | Core-supply reset, active low, asynchronous |
| mode_we | input | 1 | Write strobe for the length field |
| mode_wdata | input | LEN_W | Length value to write |
| mode_rdata | output | LEN_W | Current length field |
| rst_type | output | 3 | Recorded reset type (0 general, 7 not yet recorded) |
| bkup_rst_n | output | 1 | Backup-domain reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| proc_rst_n | output | 1 | Processor reset, active low |
| ext_rst_n | output | 1 | External reset pin drive, active low |

## Verification
The bench builds two instances side by side from the same inputs.

- **Default instance** (LEN_RST = 0): covers the minimum two-cycle pin stretch and the shortest path to processor release.
- **Second instance** (LEN_RST = 3): has a 16-cycle stretch. This window is wide enough to write the mode field in the middle of the stretch and to reassert the core reset while only the backup reset is released.

STARTUP_CYC stays at 2 in both instances.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    localparam int TYPE_W = 3;

    typedef enum logic [TYPE_W-1:0] {
        RT_GENERAL = 3'd0,
        RT_PENDING = 3'd7
    } rst_type_e;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_STRETCH,
        ST_STARTUP,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/rsm_sync.sv
module rsm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_q;

    // Asynchronous assertion, synchronous release.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rsm_regs.sv
module rsm_regs
    import rsm_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int LEN_RST = 0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             type_latch,
    output logic [LEN_W-1:0] len_q,
    output rst_type_e        type_q
);
    localparam logic [LEN_W-1:0] LenReset = LEN_W'(LEN_RST);

    // Length field: cleared to its reset value by every general reset.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)    len_q <= LenReset;
        else if (wr_en) len_q <= wr_len;
    end

    // Reset type: recorded only when the processor reset is released.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)         type_q <= RT_PENDING;
        else if (type_latch) type_q <= RT_GENERAL;
    end
endmodule

// File: rtl/rsm_seq.sv
module rsm_seq
    import rsm_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int STARTUP_CYC = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             sync_n,
    input  logic [LEN_W-1:0] len,
    output logic             bkup_n,
    output logic             periph_n,
    output logic             proc_n,
    output logic             ext_n,
    output logic             type_latch
);
    localparam int            CNT_W       = (1 << LEN_W) + 1;
    localparam logic [CNT_W-1:0] StartupLast = CNT_W'(STARTUP_CYC - 1);
    localparam logic [CNT_W-1:0] One         = CNT_W'(1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic [LEN_W:0]   shamt;

    assign shamt = {1'b0, len} + (LEN_W + 1)'(1);

    // State, counter and captured limit.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        unique case (state_q)
            ST_HOLD: begin
                if (sync_n) begin
                    state_d = ST_STRETCH;
                    cnt_d   = '0;
                    lim_d   = One << shamt;
                end
            end
            ST_STRETCH: begin
                if (cnt_q == lim_q - One) begin
                    state_d = ST_STARTUP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + One;
                end
            end
            ST_STARTUP: begin
                if (cnt_q == StartupLast) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + One;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Registered outputs decoded from the next state: glitch-free reset lines.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            bkup_n   <= 1'b0;
            ext_n    <= 1'b0;
            periph_n <= 1'b0;
            proc_n   <= 1'b0;
        end else begin
            bkup_n   <= (state_d != ST_HOLD);
            ext_n    <= (state_d == ST_STARTUP) || (state_d == ST_RUN);
            periph_n <= (state_d == ST_RUN);
            proc_n   <= (state_d == ST_RUN);
        end
    end

    assign type_latch = (state_q == ST_STARTUP) && (state_d == ST_RUN);

    assert_bkup_first_R4: assert property (@(posedge clk) disable iff (!arst_n)
        periph_n |-> bkup_n);
    assert_ext_before_proc_R4: assert property (@(posedge clk) disable iff (!arst_n)
        proc_n |-> ext_n);
    assert_pair_together_R4: assert property (@(posedge clk) disable iff (!arst_n)
        periph_n == proc_n);
    assert_min_stretch_R3: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(ext_n) |-> $past(bkup_n, 2));
    assert_released_sticky_R9: assert property (@(posedge clk) disable iff (!arst_n)
        proc_n |=> (proc_n && ext_n && bkup_n));
endmodule

// File: rtl/rst_state_mgr.sv
module rst_state_mgr
    import rsm_pkg::*;
#(
    parameter int LEN_W       = 4,
    parameter int LEN_RST     = 0,
    parameter int STARTUP_CYC = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             slow_clk,
    input  logic             core_rst_n,
    input  logic             mode_we,
    input  logic [LEN_W-1:0] mode_wdata,
    output logic [LEN_W-1:0] mode_rdata,
    output logic [2:0]       rst_type,
    output logic             bkup_rst_n,
    output logic             periph_rst_n,
    output logic             proc_rst_n,
    output logic             ext_rst_n
);
    logic      sync_n;
    logic      type_latch;
    rst_type_e type_q;

    rsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (slow_clk),
        .arst_n (core_rst_n),
        .sync_n (sync_n)
    );

    rsm_regs #(.LEN_W(LEN_W), .LEN_RST(LEN_RST)) u_regs (
        .clk        (slow_clk),
        .arst_n     (core_rst_n),
        .wr_en      (mode_we),
        .wr_len     (mode_wdata),
        .type_latch (type_latch),
        .len_q      (mode_rdata),
        .type_q     (type_q)
    );

    rsm_seq #(.LEN_W(LEN_W), .STARTUP_CYC(STARTUP_CYC)) u_seq (
        .clk        (slow_clk),
        .arst_n     (core_rst_n),
        .sync_n     (sync_n),
        .len        (mode_rdata),
        .bkup_n     (bkup_rst_n),
        .periph_n   (periph_rst_n),
        .proc_n     (proc_rst_n),
        .ext_n      (ext_rst_n),
        .type_latch (type_latch)
    );

    assign rst_type = type_q;

    assert_type_on_release_R5: assert property (@(posedge slow_clk) disable iff (!core_rst_n)
        $rose(proc_rst_n) |-> (type_q == RT_GENERAL));
    assert_type_pending_R5: assert property (@(posedge slow_clk) disable iff (!core_rst_n)
        !proc_rst_n |-> (type_q == RT_PENDING));
    assert_bkup_after_sync_R2: assert property (@(posedge slow_clk) disable iff (!core_rst_n)
        $rose(bkup_rst_n) |-> $past(sync_n));
endmodule

// File: tb/test_rst_state_mgr.sv
`timescale 1ns/1ps
module test_rst_state_mgr;
    localparam int LA = 2;   // stretch of default instance (len 0)
    localparam int LB = 16;  // stretch of second instance (len 3)

    logic       slow_clk = 1'b0;
    logic       core_rst_n;
    logic       mode_we;
    logic [3:0] mode_wdata;
    logic [3:0] rd_a, rd_b;
    logic [2:0] ty_a, ty_b;
    logic       bk_a, pe_a, pr_a, ex_a;
    logic       bk_b, pe_b, pr_b, ex_b;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 slow_clk = ~slow_clk;

    rst_state_mgr i_rst_state_mgr (
        .slow_clk(slow_clk), .core_rst_n(core_rst_n), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .mode_rdata(rd_a), .rst_type(ty_a),
        .bkup_rst_n(bk_a), .periph_rst_n(pe_a), .proc_rst_n(pr_a), .ext_rst_n(ex_a));

    rst_state_mgr #(.LEN_RST(3)) i_rst_state_mgr_long (
        .slow_clk(slow_clk), .core_rst_n(core_rst_n), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .mode_rdata(rd_b), .rst_type(ty_b),
        .bkup_rst_n(bk_b), .periph_rst_n(pe_b), .proc_rst_n(pr_b), .ext_rst_n(ex_b));

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Compare one instance at edge k after release against R2..R5/R9.
    task automatic check_edge(input string who, input int k, input int len_cyc,
                              input logic b, input logic e, input logic p,
                              input logic q, input logic [2:0] t);
        string rel;
        rel = (k > 5 + len_cyc) ? "R9" : "R4";
        check($sformatf("R2 %s bkup k=%0d", who, k), int'(b), int'(k >= 3));
        check($sformatf("R3 %s ext k=%0d", who, k), int'(e), int'(k >= 3 + len_cyc));
        check($sformatf("%s %s periph k=%0d", rel, who, k), int'(p), int'(k >= 5 + len_cyc));
        check($sformatf("%s %s proc k=%0d", rel, who, k), int'(q), int'(k >= 5 + len_cyc));
        check($sformatf("R5 %s type k=%0d", who, k), int'(t), (k >= 5 + len_cyc) ? 0 : 7);
    endtask

    task automatic check_all_low(input string tag);
        check({tag, " A outputs"}, int'({bk_a, ex_a, pe_a, pr_a}), 0);
        check({tag, " B outputs"}, int'({bk_b, ex_b, pe_b, pr_b}), 0);
        check("R5 A type pending", int'(ty_a), 7);
        check("R5 B type pending", int'(ty_b), 7);
    endtask

    // Release core reset and follow the whole sequence; optional mode write.
    task automatic run_seq(input int wr_at, input logic [3:0] wr_val);
        @(negedge slow_clk);
        core_rst_n = 1'b1;
        for (int k = 1; k <= LB + 9; k++) begin
            @(posedge slow_clk);
            @(negedge slow_clk);
            check_edge("A", k, LA, bk_a, ex_a, pe_a, pr_a, ty_a);
            check_edge("B", k, LB, bk_b, ex_b, pe_b, pr_b, ty_b);
            if (k == wr_at) begin
                mode_we    = 1'b1;
                mode_wdata = wr_val;
            end else begin
                mode_we = 1'b0;
            end
        end
        mode_we = 1'b0;
    endtask

    task automatic general_reset(input string tag);
        @(negedge slow_clk);
        core_rst_n = 1'b0;
        #1;
        check_all_low(tag);
        check("R6 A mode back to reset value", int'(rd_a), 0);
        check("R6 B mode back to reset value", int'(rd_b), 3);
    endtask

    task automatic test_reset_state;
        repeat (3) @(negedge slow_clk);
        check_all_low("R1 reset");
        check("R6 A mode reset value", int'(rd_a), 0);
        check("R6 B mode reset value", int'(rd_b), 3);
    endtask

    task automatic test_plain_sequence;
        run_seq(0, 4'd0);
    endtask

    // R7: write mid-stretch of B; captured length stays 3 -> 16 cycles.
    task automatic test_write_mid_sequence;
        general_reset("R1 reassert");
        run_seq(6, 4'd5);
        check("R6 A readback", int'(rd_a), 5);
        check("R6 B readback", int'(rd_b), 5);
        check("R7 B proc released with old length", int'(pr_b), 1);
        general_reset("R1 after write");
    endtask

    // R8: abort during B's stretch, then a full clean sequence.
    task automatic test_abort_mid_sequence;
        @(negedge slow_clk);
        core_rst_n = 1'b1;
        repeat (10) @(negedge slow_clk);
        check("R8 B bkup released before abort", int'(bk_b), 1);
        check("R8 B ext still low before abort", int'(ex_b), 0);
        core_rst_n = 1'b0;
        #1;
        check_all_low("R8 abort");
        repeat (2) @(negedge slow_clk);
        run_seq(0, 4'd0);
    endtask

    initial begin
        core_rst_n = 1'b0;
        mode_we    = 1'b0;
        mode_wdata = '0;
        test_reset_state();
        test_plain_sequence();
        test_write_mid_sequence();
        test_abort_mid_sequence();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge slow_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule